// File: doc/BRIEF.md
# Bus Clock Divider Factor Search

This unit picks the two divider factors of a serial bus clock generator. Given the frequency of the reference clock and the bus frequency that is wanted, it walks a fixed grid of candidate pairs, an exponent factor N of 3 bits and a linear factor M of 4 bits. For each pair it computes the bus frequency that the pair would produce. It keeps the pair whose frequency comes closest to the request from below. The result is given as the two factors and also as one packed field that a divider control register can take directly.

A search begins on a one-cycle start pulse. The unit captures both frequencies at that edge. It then evaluates one candidate at a time with a bit-serial restoring divider and raises a done level when the search is over. If every candidate lands above the request, a failure flag rises together with done. The result stays on the outputs until the next accepted start.

Top module: `baud_search`

## Requirements
- R1: The bus frequency of a pair (N, M) is the integer quotient floor(ref / (10 × (M+1) × 2^(N+1))), with all frequencies 32-bit unsigned.
- R2: Candidates are visited with N as the outer index from 0 to 7 and M as the inner index from 0 to 15. A candidate replaces the current best only when its difference is strictly smaller, so of two equal differences the earlier one is kept.
- R3: The chosen pair gives the smallest non-negative difference (request − candidate), which is the largest candidate frequency that does not exceed the request. The best difference at the start of a search is larger than any possible difference.
- R4: The search stops at the first candidate whose difference is zero. No later candidate is evaluated.
- R5: If no candidate is at or below the request, fail_o is 1 with done_o, and n_o and m_o are both 0. On success fail_o is 0.
- R6: divreg_o carries M in bits [6:3] and N in bits [2:0].
- R7: Once done_o is 1, done_o, fail_o, n_o, m_o and divreg_o keep their values until the next start pulse. Changes on the frequency inputs have no effect on them.
- R8: done_o rises exactly 34 × (k+1) clock edges after the edge that samples start, where k = 16·N + M is the position of the last candidate evaluated.
- R9: A start pulse that arrives while a search is running is ignored. The running search finishes with the frequencies it captured, and its timing is unchanged.
- R10: After reset, done_o and fail_o are 0 and n_o, m_o and divreg_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a search when the unit is not busy |
| ref_hz_i | input | 32 | Reference clock frequency, captured on start |
| bus_hz_i | input | 32 | Requested bus frequency, captured on start |
| n_o | output | 3 | Chosen exponent factor N |
| m_o | output | 4 | Chosen linear factor M |
| divreg_o | output | 7 | Packed factors for the divider register |
| done_o | output | 1 | Search finished; held until the next start |
| fail_o | output | 1 | No candidate at or below the request |

## Verification
On every cycle, the assertions check three things. Each quotient from the serial divider must be the exact integer quotient of the captured operands. The best difference may only fall while a search runs. After done, the results must stay frozen, and a failure must leave zero factors. The bench's sweeps are the only place that shows the rest. That covers the visiting order and the earliest-wins tie rule, the early stop and the exact latency it produces, the choice of the correct pair across many frequency combinations, and the start pulse that is ignored during a search. A bench model computes these from the formula alone.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   // search control states
   typedef enum logic [1:0] {
      BS_IDLE = 2'd0,
      BS_KICK = 2'd1,
      BS_WAIT = 2'd2,
      BS_FIN  = 2'd3
   } bs_state_e;

endpackage

// File: rtl/bsr_divider.sv
// Bit-serial restoring divider: one quotient bit per cycle, W cycles per quotient.
module bsr_divider #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         go_i,
   input  logic [W-1:0] dvd_i,
   input  logic [W-1:0] dvs_i,
   output logic [W-1:0] quo_o,
   output logic         dv_o
);
   localparam int CNT_W = $clog2(W + 1);

   logic [W-1:0]     dvd_q, dvs_q, sh_q, quo_q, rem_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, dv_q;
   logic [W:0]       shifted, trial;

   assign shifted = {rem_q, sh_q[W-1]};
   assign trial   = shifted - {1'b0, dvs_q};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dvd_q  <= '0;
         dvs_q  <= '0;
         sh_q   <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         dv_q   <= 1'b0;
      end else begin
         dv_q <= 1'b0;
         if (go_i) begin
            dvd_q  <= dvd_i;
            dvs_q  <= dvs_i;
            sh_q   <= dvd_i;
            quo_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= CNT_W'(W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
            if (!trial[W]) begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= shifted[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               dv_q   <= 1'b1;
            end
         end
      end
   end

   assign quo_o = quo_q;
   assign dv_o  = dv_q;

   logic [2*W-1:0] prod_w;
   assign prod_w = {{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q};

   // R1
   div_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dv_q |-> (prod_w <= {{W{1'b0}}, dvd_q}) &&
               (({{W{1'b0}}, dvd_q} - prod_w) < {{W{1'b0}}, dvs_q}));

endmodule

// File: rtl/bsr_grid.sv
// Candidate index walker: N outer, M inner; forms the divisor of the current pair.
module bsr_grid #(
   parameter int FREQ_W = 32,
   parameter int N_W    = 3,
   parameter int M_W    = 4,
   parameter int SCALE  = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              step_i,
   output logic [N_W-1:0]    n_o,
   output logic [M_W-1:0]    m_o,
   output logic              last_o,
   output logic [FREQ_W-1:0] divisor_o
);
   localparam int IDX_W = N_W + M_W;

   logic [IDX_W-1:0]  idx_q;
   logic [FREQ_W-1:0] base_w;
   logic [N_W:0]      shamt_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      idx_q <= '0;
      else if (clear_i) idx_q <= '0;
      else if (step_i)  idx_q <= idx_q + 1'b1;
   end

   assign n_o     = idx_q[IDX_W-1:M_W];
   assign m_o     = idx_q[M_W-1:0];
   assign last_o  = &idx_q;
   assign base_w  = FREQ_W'(SCALE) * (FREQ_W'(m_o) + FREQ_W'(1));
   assign shamt_w = {1'b0, n_o} + (N_W+1)'(1);
   assign divisor_o = base_w << shamt_w;

endmodule

// File: rtl/baud_search.sv
module baud_search
   import bsr_pkg::*;
#(
   parameter int FREQ_W = 32,
   parameter int N_W    = 3,
   parameter int M_W    = 4,
   parameter int SCALE  = 10
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [FREQ_W-1:0]  ref_hz_i,
   input  logic [FREQ_W-1:0]  bus_hz_i,
   output logic [N_W-1:0]     n_o,
   output logic [M_W-1:0]     m_o,
   output logic [N_W+M_W-1:0] divreg_o,
   output logic               done_o,
   output logic               fail_o
);
   localparam int              REG_W  = N_W + M_W;
   localparam int              SH_MAX = M_W + (1 << N_W);
   localparam longint unsigned MAXDIV = longint'(SCALE) << SH_MAX;

   // elaboration-time parameter checks
   if (FREQ_W < 8 || FREQ_W > 62) begin : g_bad_freq_w
      $error("baud_search: FREQ_W out of range");
   end
   if (N_W < 1 || N_W > 4 || M_W < 1 || M_W > 8) begin : g_bad_factor_w
      $error("baud_search: factor widths out of range");
   end
   if (SCALE < 1 || (MAXDIV >> FREQ_W) != 0) begin : g_bad_scale
      $error("baud_search: largest divisor does not fit FREQ_W");
   end

   bs_state_e         st_q;
   logic [FREQ_W-1:0] ref_q, req_q;
   logic [FREQ_W:0]   best_q;
   logic [N_W-1:0]    bn_q;
   logic [M_W-1:0]    bm_q;
   logic              found_q, done_q, fail_q;

   logic [N_W-1:0]    gn_w;
   logic [M_W-1:0]    gm_w;
   logic              last_w;
   logic [FREQ_W-1:0] dvs_w, quo_w, delta_w;
   logic              dv_w, accept_w, take_w, hit0_w, finish_w, step_w;

   assign accept_w = ((st_q == BS_IDLE) || (st_q == BS_FIN)) && start_i;
   assign delta_w  = req_q - quo_w;
   assign take_w   = dv_w && (req_q >= quo_w) && ({1'b0, delta_w} < best_q);
   assign hit0_w   = take_w && (delta_w == '0);
   assign finish_w = dv_w && (hit0_w || last_w);
   assign step_w   = dv_w && !finish_w;

   bsr_grid #(.FREQ_W(FREQ_W), .N_W(N_W), .M_W(M_W), .SCALE(SCALE)) u_grid (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (accept_w),
      .step_i    (step_w),
      .n_o       (gn_w),
      .m_o       (gm_w),
      .last_o    (last_w),
      .divisor_o (dvs_w)
   );

   bsr_divider #(.W(FREQ_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (st_q == BS_KICK),
      .dvd_i  (ref_q),
      .dvs_i  (dvs_w),
      .quo_o  (quo_w),
      .dv_o   (dv_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= BS_IDLE;
         ref_q   <= '0;
         req_q   <= '0;
         best_q  <= '1;
         bn_q    <= '0;
         bm_q    <= '0;
         found_q <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         unique case (st_q)
            BS_IDLE, BS_FIN: begin
               if (start_i) begin
                  st_q    <= BS_KICK;
                  ref_q   <= ref_hz_i;
                  req_q   <= bus_hz_i;
                  best_q  <= '1;
                  bn_q    <= '0;
                  bm_q    <= '0;
                  found_q <= 1'b0;
                  done_q  <= 1'b0;
                  fail_q  <= 1'b0;
               end
            end
            BS_KICK: st_q <= BS_WAIT;
            BS_WAIT: begin
               if (take_w) begin
                  best_q  <= {1'b0, delta_w};
                  bn_q    <= gn_w;
                  bm_q    <= gm_w;
                  found_q <= 1'b1;
               end
               if (finish_w) begin
                  st_q   <= BS_FIN;
                  done_q <= 1'b1;
                  fail_q <= !(found_q || take_w);
               end else if (step_w) begin
                  st_q <= BS_KICK;
               end
            end
            default: st_q <= BS_IDLE;
         endcase
      end
   end

   assign n_o      = bn_q;
   assign m_o      = bm_q;
   assign divreg_o = {bm_q, bn_q};
   assign done_o   = done_q;
   assign fail_o   = fail_q;

   // R3
   best_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == BS_KICK || st_q == BS_WAIT) |=> best_q <= $past(best_q));

   // R7
   result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && !start_i) |=> done_q && $stable(bn_q) && $stable(bm_q) && $stable(fail_q));

   // R5
   fail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fail_q |-> (bn_q == '0) && (bm_q == '0) && done_q);

   // R9
   busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == BS_WAIT && !dv_w) |=> st_q == BS_WAIT && $stable(req_q) && $stable(ref_q));

endmodule

// File: tb/sim_baud_search.sv
module sim_baud_search;
   localparam int CLK_PERIOD = 10;
   localparam int FW         = 32;
   localparam int CYC        = FW + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ref_hz = '0;
   logic [31:0] bus_hz = '0;
   logic [2:0]  n_o;
   logic [3:0]  m_o;
   logic [6:0]  divreg;
   logic        done, fail;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   baud_search u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .ref_hz_i(ref_hz), .bus_hz_i(bus_hz),
      .n_o(n_o), .m_o(m_o), .divreg_o(divreg),
      .done_o(done), .fail_o(fail)
   );

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // bench model from R1..R5 and R8
   task automatic model(input longint unsigned rf, input longint unsigned rq,
                        output int en, output int em, output bit ef, output int ek);
      longint unsigned best = 64'h1_0000_0000;
      en = 0; em = 0; ef = 1; ek = 127;
      for (int idx = 0; idx < 128; idx++) begin
         longint unsigned dv = 10 * ((idx % 16) + 1) * (longint'(2) << (idx / 16));
         longint unsigned cand = rf / dv;
         if (rq >= cand && (rq - cand) < best) begin
            best = rq - cand; en = idx / 16; em = idx % 16; ef = 0;
            if (best == 0) begin ek = idx; break; end
         end
      end
   endtask

   task automatic run(input logic [31:0] rf, input logic [31:0] rq, input int disturb_at);
      int en, em, ek, cnt;
      bit ef;
      logic [2:0] hn; logic [3:0] hm; logic hf;
      model(rf, rq, en, em, ef, ek);
      @(negedge clk);
      ref_hz = rf; bus_hz = rq; start = 1'b1;
      cnt = 0;
      @(posedge clk); cnt++;
      @(negedge clk); start = 1'b0;
      while (!done && cnt < 5000) begin
         @(posedge clk); cnt++;
         @(negedge clk);
         if (cnt == disturb_at) begin
            ref_hz = 32'd7; bus_hz = 32'd5; start = 1'b1;   // R9 mid-search start
         end else begin
            start = 1'b0;
         end
      end
      chk(done == 1'b1, "R8 done", done, 1);
      chk(cnt - 1 == CYC * (ek + 1), "R8/R4 latency", cnt - 1, CYC * (ek + 1));
      chk(fail == ef, "R5 fail", fail, ef);
      chk(n_o == en, "R3/R2 n", n_o, en);
      chk(m_o == em, "R3/R2 m", m_o, em);
      chk(divreg == {em[3:0], en[2:0]}, "R6 divreg", divreg, {em[3:0], en[2:0]});
      if (disturb_at > 0) chk(n_o == en && m_o == em, "R9 ignored start", {m_o, n_o}, {em[3:0], en[2:0]});
      // R7: inputs change without start, results hold
      hn = n_o; hm = m_o; hf = fail;
      ref_hz = ~rf; bus_hz = rq ^ 32'h5a5a;
      repeat (6) @(negedge clk);
      chk(done && n_o == hn && m_o == hm && fail == hf, "R7 hold", {done, m_o, n_o, fail}, {1'b1, hm, hn, hf});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(done == 0 && fail == 0, "R10 flags", {done, fail}, 0);
      chk(n_o == 0 && m_o == 0 && divreg == 0, "R10 factors", {divreg, m_o, n_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run(32'd1_250_000, 32'd62_500, -1);         // R4 exact at first pair
      run(32'd240_000, 32'd1_000, -1);            // R4 exact mid-grid
      run(32'd0, 32'd0, -1);                      // R2 tie, all zero
      run(32'd0, 32'd5, -1);                      // R2 tie, full scan
      run(32'd100_000_000, 32'd1_000, -1);        // R5 fail
      run(32'd100_000_000, 32'd100_000, -1);      // R1/R3
      run(32'd100_000_000, 32'd400_000, -1);      // R3
      run(32'd166_666_667, 32'd100_000, -1);      // R3
      run(32'd25_000_000, 32'd100_000, -1);       // R3
      run(32'hFFFF_FFFF, 32'hFFFF_FFFF, -1);      // R1 widest values
      run(32'd100_000_000, 32'd100_000, 60);      // R9
      lf = 32'h1234_5677;
      for (int i = 0; i < 4; i++) begin
         lf = lf * 32'd1664525 + 32'd1013904223;
         run(lf, {12'd0, lf[19:0]} ^ 32'h100, -1); // R1/R3 spread
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule